// File: doc/BRIEF.md
# Per-Bit Port With External Bus Takeover

This block is one general-purpose I/O port of configurable width. Each pin is set on its own. As a plain port pin it is either an input or an output. Its other choice is to hand the pin to the external memory bus controller. Software sets the port up through three writable registers on a simple register interface:

- a bus-select register, which picks port or bus use for each bit;
- a direction register;
- an output latch.

Pin levels come back through a two-flop synchronizer. Both software and the bus controller see the synchronized value.

A parameter picks the variant. With `BUS_BIDIR = 1` (the 16-bit data-capable port), a pin taken by the bus follows the controller's own output enable. That makes it a shared address/data line. With `BUS_BIDIR = 0` (the 8-bit high-address port), a taken pin is always driven and carries an address bit. The bus takeover applies only while the external expansion mode input is high. When that input is low, every bit behaves as a port pin, whatever its bus-select bit says.

Each bit sits in one of three named states, derived every cycle:
- `PM_IN` means port input.
- `PM_OUT` means port output.
- `PM_BUS` means the bus controller owns the pin.

The state is chosen in this order:
- `PM_BUS` when the bus-select bit and the expansion mode are both 1.
- Otherwise `PM_OUT` when the direction bit is 1.
- Otherwise `PM_IN`.

The state changes at once when any of those three inputs changes. Register writes take effect at the clock edge on which `reg_we` is sampled high.

Top module: `gpx_port`

## Requirements
- R1: After reset the bus-select, direction and latch registers read back as 0, and every `pin_oe` bit is 0.
- R2: A bit in state `PM_OUT` drives `pin_oe` = 1 and `pin_out` = its latch bit. A latch write (`reg_sel` = 2) is visible on `pin_out` right after its clock edge.
- R3: A bit in state `PM_IN` drives `pin_oe` = 0.
- R4: Reading `reg_sel` = 3 returns, per bit, one of two values. For a `PM_OUT` bit it is the latch bit. For a `PM_IN` or `PM_BUS` bit it is the synchronized pin level.
- R5: A pin level change shows in the synchronized readback after the second rising clock edge, not after the first.
- R6: With `BUS_BIDIR` = 1, a `PM_BUS` bit has `pin_out` = `bus_out` and `pin_oe` = `bus_oe`. Direction and latch have no effect on it.
- R7: With `BUS_BIDIR` = 0, a `PM_BUS` bit has `pin_oe` = 1 and `pin_out` = `bus_out`, whatever `bus_oe` is.
- R8: While `ext_mode` = 0, bits whose bus-select bit is 1 behave as port pins, following direction and latch.
- R9: Latch writes made while a bit is in `PM_BUS` are kept. They drive the pin once the bit returns to `PM_OUT`.
- R10: `reg_sel` 0, 1 and 2 read back bus-select, direction and latch. A write with `reg_sel` = 3 changes none of them.
- R11: `bus_rd` carries the synchronized level of every pin, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 bus-select, 1 direction, 2 latch, 3 pin read |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Read data for the selected register |
| ext_mode | input | 1 | External expansion mode active |
| bus_out | input | W | Address/data from the bus controller |
| bus_oe | input | W | Output enable from the bus controller |
| bus_rd | output | W | Synchronized pin levels for the bus controller |
| pin_in | input | W | Pin levels from the pads |
| pin_out | output | W | Pin output values |
| pin_oe | output | W | Pin output enables |

## Verification
The synchronizer check assumes that reset has been released for at least two edges before it compares against earlier pin levels. The bench therefore holds reset over several edges and only then starts changing pins. The register checks assume `reg_sel` and `reg_we` are stable at the sampling edge. The bench drives them on the falling edge only.

The bus-takeover checks assume `ext_mode`, `bus_out` and `bus_oe` change away from the clock edge, and the bench does this. Pins are set at least two edges before any readback comparison, so the synchronizer is always settled when a swept pattern is checked.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    // Register select codes
    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_LAT  = 2'd2,
        SEL_PIN  = 2'd3
    } gpx_sel_e;

    // Per-bit pin ownership state
    typedef enum logic [1:0] {
        PM_IN  = 2'd0,
        PM_OUT = 2'd1,
        PM_BUS = 2'd2
    } pin_mode_e;
endpackage

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [1:0]   sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mode_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lat_q
);
    gpx_sel_e sel_e;
    assign sel_e = gpx_sel_e'(sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            dir_q  <= '0;
            lat_q  <= '0;
        end else if (we) begin
            unique case (sel_e)
                SEL_MODE: mode_q <= wdata;
                SEL_DIR:  dir_q  <= wdata;
                SEL_LAT:  lat_q  <= wdata;
                SEL_PIN:  ;
            endcase
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_q == '0 && dir_q == '0 && lat_q == '0));
    // R2
    lat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == 2'd2) |=> (lat_q == $past(wdata)));
    // R9
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == 2'd2) |=> $stable(lat_q));
    // R10
    pin_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == 2'd3) |=> ($stable(mode_q) && $stable(dir_q) && $stable(lat_q)));
endmodule

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            // R5
            sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpx_pinmux.sv
module gpx_pinmux
    import gpx_pkg::*;
#(
    parameter int W         = 16,
    parameter bit BUS_BIDIR = 1'b1
) (
    input  logic         ext_mode,
    input  logic [W-1:0] mode_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] lat_q,
    input  logic [W-1:0] bus_out,
    input  logic [W-1:0] bus_oe,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_pin
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            pin_mode_e st;
            logic      bus_en;

            if (BUS_BIDIR) begin : g_bidir
                assign bus_en = bus_oe[i];
            end else begin : g_addr
                assign bus_en = 1'b1;
            end

            always_comb begin
                if (mode_q[i] && ext_mode) st = PM_BUS;
                else if (dir_q[i])         st = PM_OUT;
                else                       st = PM_IN;
            end

            always_comb begin
                unique case (st)
                    PM_BUS: begin
                        pin_out[i] = bus_out[i];
                        pin_oe[i]  = bus_en;
                        rd_pin[i]  = pin_sync[i];
                    end
                    PM_OUT: begin
                        pin_out[i] = lat_q[i];
                        pin_oe[i]  = 1'b1;
                        rd_pin[i]  = lat_q[i];
                    end
                    default: begin
                        pin_out[i] = lat_q[i];
                        pin_oe[i]  = 1'b0;
                        rd_pin[i]  = pin_sync[i];
                    end
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
#(
    parameter int W         = 16,
    parameter bit BUS_BIDIR = 1'b1,
    parameter int SYNC_STG  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_we,
    input  logic [1:0]   reg_sel,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         ext_mode,
    input  logic [W-1:0] bus_out,
    input  logic [W-1:0] bus_oe,
    output logic [W-1:0] bus_rd,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    logic [W-1:0] mode_q, dir_q, lat_q, pin_sync, rd_pin;

    gpx_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .mode_q(mode_q), .dir_q(dir_q), .lat_q(lat_q)
    );

    gpx_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpx_pinmux #(.W(W), .BUS_BIDIR(BUS_BIDIR)) u_mux (
        .ext_mode(ext_mode), .mode_q(mode_q), .dir_q(dir_q), .lat_q(lat_q),
        .bus_out(bus_out), .bus_oe(bus_oe), .pin_sync(pin_sync),
        .pin_out(pin_out), .pin_oe(pin_oe), .rd_pin(rd_pin)
    );

    assign bus_rd = pin_sync;

    always_comb begin
        unique case (gpx_sel_e'(reg_sel))
            SEL_MODE: reg_rdata = mode_q;
            SEL_DIR:  reg_rdata = dir_q;
            SEL_LAT:  reg_rdata = lat_q;
            SEL_PIN:  reg_rdata = rd_pin;
        endcase
    end

    // R3 and R8
    port_in_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~(mode_q & {W{ext_mode}}) & ~dir_q & pin_oe) == '0));
    // R2 and R8
    port_out_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((~(mode_q & {W{ext_mode}}) & dir_q) & ~pin_oe) == '0));

    generate
        if (!BUS_BIDIR) begin : g_addr_chk
            // R7
            addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((mode_q & {W{ext_mode}} & ~pin_oe) == '0));
        end
    endgenerate
endmodule

// File: tb/tb_gpx_port.sv
module tb_gpx_port;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic        ext_mode = 1'b0;

    logic [15:0] bo16 = '0, boe16 = '0, pi16 = '0;
    logic [15:0] rd16, br16, po16, oe16;
    logic [7:0]  bo8 = '0, boe8 = '0, pi8 = '0;
    logic [7:0]  rd8, br8, po8, oe8;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    gpx_port #(.W(16), .BUS_BIDIR(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rd16), .ext_mode(ext_mode),
        .bus_out(bo16), .bus_oe(boe16), .bus_rd(br16),
        .pin_in(pi16), .pin_out(po16), .pin_oe(oe16)
    );

    gpx_port #(.W(8), .BUS_BIDIR(1'b0)) dut_a (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata[7:0]), .reg_rdata(rd8), .ext_mode(ext_mode),
        .bus_out(bo8), .bus_oe(boe8), .bus_rd(br8),
        .pin_in(pi8), .pin_out(po8), .pin_oe(oe8)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Arithmetic model of the requirements
    function automatic logic [15:0] m_oe(logic [15:0] m, logic [15:0] d, logic e,
                                         logic [15:0] boe, bit bidir);
        logic [15:0] c = m & {16{e}};
        return (c & (bidir ? boe : 16'hFFFF)) | (~c & d);
    endfunction
    function automatic logic [15:0] m_out(logic [15:0] m, logic e, logic [15:0] l,
                                          logic [15:0] b);
        logic [15:0] c = m & {16{e}};
        return (c & b) | (~c & l);
    endfunction
    function automatic logic [15:0] m_rd(logic [15:0] m, logic [15:0] d, logic e,
                                         logic [15:0] l, logic [15:0] p);
        logic [15:0] o = ~(m & {16{e}}) & d;
        return (o & l) | (~o & p);
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 oe16 in reset", oe16, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int s = 0; s < 3; s++) begin
            reg_sel = 2'(s); #1;
            chk("R1 reg16 after reset", rd16, 16'h0);
            chk("R1 reg8 after reset", {8'h0, rd8}, 16'h0);
        end
        chk("R1 oe8", {8'h0, oe8}, 16'h0);

        // R5 synchronizer latency: port input, pins change
        pi16 = 16'hA5C3; pi8 = 8'h3C; reg_sel = 2'd3;
        @(negedge clk);
        chk("R5 one edge still old", rd16, 16'h0);
        chk("R5 one edge still old 8", {8'h0, rd8}, 16'h0);
        @(negedge clk);
        chk("R5 two edges new", rd16, 16'hA5C3);
        chk("R5 two edges new 8", {8'h0, rd8}, 16'h003C);

        // Sweep of mode, direction, latch, pins, bus and expansion mode
        for (int k = 0; k < 96; k++) begin
            logic [15:0] m, d, l;
            logic        e;
            m = 16'(k * 16'h3A5B) ^ 16'h1234;
            d = 16'(k * 16'h9E37) ^ 16'h0F0F;
            l = 16'(k * 16'h6D2B) + 16'h5A5A;
            e = (k % 3) != 0;
            @(negedge clk);
            ext_mode = e;
            pi16  = 16'(k * 16'h4F1D) ^ 16'hC3C3;
            bo16  = 16'(k * 16'h2B79) ^ 16'h00FF;
            boe16 = 16'(k * 16'h71C5);
            pi8   = pi16[15:8];
            bo8   = bo16[7:0];
            boe8  = boe16[7:0];
            wr(2'd0, m);
            wr(2'd1, d);
            wr(2'd2, l);
            // R2, R3, R6, R8
            chk("R2,R3,R6,R8 oe16", oe16, m_oe(m, d, e, boe16, 1'b1));
            chk("R2,R6,R8 out16", po16, m_out(m, e, l, bo16));
            // R7 address-only variant
            chk("R2,R3,R7,R8 oe8", {8'h0, oe8},
                {8'h0, m_oe({8'h0, m[7:0]}, {8'h0, d[7:0]}, e, 16'h0, 1'b0) & 16'h00FF});
            chk("R7,R8 out8", {8'h0, po8},
                m_out({8'h0, m[7:0]}, e, {8'h0, l[7:0]}, {8'h0, bo8}) & 16'h00FF);
            // R11
            chk("R11 bus_rd16", br16, pi16);
            chk("R11 bus_rd8", {8'h0, br8}, {8'h0, pi8});
            // R4
            reg_sel = 2'd3; #1;
            chk("R4 pin read16", rd16, m_rd(m, d, e, l, pi16));
            chk("R4 pin read8", {8'h0, rd8},
                m_rd({8'h0, m[7:0]}, {8'h0, d[7:0]}, e, {8'h0, l[7:0]}, {8'h0, pi8}) & 16'h00FF);
            // R10
            reg_sel = 2'd0; #1; chk("R10 mode read", rd16, m);
            reg_sel = 2'd1; #1; chk("R10 dir read", rd16, d);
            reg_sel = 2'd2; #1; chk("R10 lat read", rd16, l);
        end

        // R10 write to pin select is ignored
        wr(2'd0, 16'h1111); wr(2'd1, 16'h2222); wr(2'd2, 16'h3333);
        wr(2'd3, 16'hFFFF);
        reg_sel = 2'd0; #1; chk("R10 sel3 write mode", rd16, 16'h1111);
        reg_sel = 2'd1; #1; chk("R10 sel3 write dir", rd16, 16'h2222);
        reg_sel = 2'd2; #1; chk("R10 sel3 write lat", rd16, 16'h3333);

        // R9 latch kept during bus ownership
        ext_mode = 1'b1; bo16 = 16'h0F0F; boe16 = 16'hFFFF; bo8 = 8'hF0;
        wr(2'd1, 16'hFFFF);
        wr(2'd0, 16'hFFFF);
        wr(2'd2, 16'hBEEF);
        chk("R6,R9 bus owns pin16", po16, 16'h0F0F);
        chk("R7,R9 bus owns pin8", {8'h0, po8}, 16'h00F0);
        wr(2'd0, 16'h0000);
        chk("R9 latch returns16", po16, 16'hBEEF);
        chk("R9 latch returns8", {8'h0, po8}, 16'h00EF);
        chk("R9 oe16 port out", oe16, 16'hFFFF);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule